// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Cell

This block models one programmable logic cell of the kind found in small complex programmable logic devices. A local routing bus enters an AND array that builds five product terms. Each term has its own masks for the true and the complemented form of every input. A select matrix then gives each product term one role. It either joins the OR sum, or it drives a register control: asynchronous preset, asynchronous clear, array clock, clock enable, or the second data input of the register. The OR sum also takes borrowed product terms from neighbouring cells and shared product terms, which arrive on ports already in inverted form. A polarity bit inverts the result.

The combinational result feeds a single storage element. That element behaves as a D, T, JK or SR flip-flop, as its configuration selects. A bypass bit sends the combinational result to the outputs instead of the register. The same selected value appears on the I/O output and on the feedback output that returns to routing. The whole configuration is held on static input ports. Every clock source is sampled with the system clock `clk`: a source "rises" on a `clk` edge where it is 1 and was 0 at the previous `clk` edge. Preset and clear act on the next `clk` edge, whether or not a clock source rises.

The register is a two-state machine with states ST_ZERO and ST_ONE. The transition ST_ZERO to ST_ONE (SET) happens on preset without clear, or on a clocked edge whose next value is 1. The transition ST_ONE to ST_ZERO (CLEAR) happens on clear, or on a clocked edge whose next value is 0 while preset is inactive. In every other case the state holds (HOLD).

Top module: `mcell_cell`

## Requirements
- R1: Product term k is 1 exactly when every input whose bit is set in `cfg_and_true[k]` is 1 and every input whose bit is set in `cfg_and_comp[k]` is 0. A term with both masks empty is constant 1.
- R2: The role code of each term is a 3-bit field: 0 sum, 1 preset, 2 clear, 3 array clock, 4 clock enable, 5 second data input (K or R). Codes 6 and 7 leave the term unused. The combinational result is the OR of all sum-role terms, all `borrow_in` bits and all `share_in` bits, XORed with `cfg_invert`.
- R3: When `cfg_bypass` is 1, `io_out` and `fb_out` show the combinational result. When it is 0, they show the register state.
- R4: D mode (`cfg_ff_kind`=0): on a clock event the register takes the combinational result. Between events it holds its value.
- R5: T mode (`cfg_ff_kind`=1): on a clock event the register toggles when the combinational result is 1 and holds when it is 0.
- R6: JK mode (`cfg_ff_kind`=2), with J the combinational result and K the OR of the role-5 terms: 00 holds, 10 sets, 01 clears, 11 toggles.
- R7: SR mode (`cfg_ff_kind`=3), with S the combinational result and R the OR of the role-5 terms: 10 sets, 01 clears, 00 and 11 both hold.
- R8: `cfg_clk_mode` selects the clock event. Mode 0 is a rise of the global clock. Mode 1 is a rise of the global clock while the OR of the role-4 terms is 1. Mode 2 is a rise of the OR of the role-3 terms. Mode 3 never clocks the register.
- R9: The global clock is `gclk_pin[cfg_pin_sel]` XOR `cfg_pin_inv`. The other pin has no effect.
- R10: Preset (OR of role-1 terms) sets the register, and clear (OR of role-2 terms, or `gclr_n` low) resets it, on the next `clk` edge with no clock event needed. Clear wins over preset, and both win over a clock event.
- R11: While `rst_n` is low at a `clk` edge, the register and the clock-rise history are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| route_in | input | NIN | Local routing bus into the AND array |
| gclk_pin | input | 2 | The two global clock pins |
| gclr_n | input | 1 | Active-low global clear |
| borrow_in | input | NPAR | Product terms borrowed from neighbouring cells |
| share_in | input | NSHR | Shared product terms, already inverted |
| cfg_and_true | input | NPT x NIN | Per-term mask of inputs used in true form |
| cfg_and_comp | input | NPT x NIN | Per-term mask of inputs used in complemented form |
| cfg_role | input | NPT x 3 | Per-term role code |
| cfg_invert | input | 1 | Polarity of the combinational result |
| cfg_ff_kind | input | 2 | Register behaviour: 0 D, 1 T, 2 JK, 3 SR |
| cfg_clk_mode | input | 2 | Clock event source |
| cfg_pin_sel | input | 1 | Global clock pin select |
| cfg_pin_inv | input | 1 | Global clock inversion |
| cfg_bypass | input | 1 | Route the combinational result to the outputs |
| io_out | output | 1 | Output toward the I/O path |
| fb_out | output | 1 | Output back to routing |

## Verification
The bench attacks the register modes where the state must be held: JK and SR with both data inputs at 0 or at 1. A design that swaps toggle and hold, or treats S=R=1 as a set, shows the wrong value after one pulse. It sets preset and clear, and global clear alone, at the same time. A design with the wrong priority leaves the register at 1. For the clock sources it holds the array clock term high across several samples, keeps the enable low during a global pulse, and pulses the unselected pin. A level-clocked or ungated design captures data there. Masks that mix true and complement forms, and empty masks, expose an AND array that ignores one mask or reads an empty mask as 0. A reference model replays random configurations and checks the cell on every edge.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

    typedef enum logic [2:0] {
        ROLE_SUM    = 3'd0,
        ROLE_PRESET = 3'd1,
        ROLE_CLEAR  = 3'd2,
        ROLE_ACLK   = 3'd3,
        ROLE_CENA   = 3'd4,
        ROLE_AUX    = 3'd5,
        ROLE_IDLE6  = 3'd6,
        ROLE_IDLE7  = 3'd7
    } pt_role_e;

    typedef enum logic [1:0] {
        FF_D  = 2'd0,
        FF_T  = 2'd1,
        FF_JK = 2'd2,
        FF_SR = 2'd3
    } ff_kind_e;

    typedef enum logic [1:0] {
        CM_GLOBAL = 2'd0,
        CM_GATED  = 2'd1,
        CM_ARRAY  = 2'd2,
        CM_OFF    = 2'd3
    } clk_mode_e;

    typedef enum logic {
        ST_ZERO = 1'b0,
        ST_ONE  = 1'b1
    } cell_st_e;

endpackage

// File: rtl/mcell_and_array.sv
module mcell_and_array #(
    parameter int NIN = 8,
    parameter int NPT = 5
) (
    input  logic [NIN-1:0]          sig_in,
    input  logic [NPT-1:0][NIN-1:0] use_true,
    input  logic [NPT-1:0][NIN-1:0] use_comp,
    output logic [NPT-1:0]          term
);

    // One wide AND per product term; an unused input contributes a 1.
    for (genvar k = 0; k < NPT; k++) begin : g_term
        assign term[k] = (&(sig_in | ~use_true[k])) & ~(|(sig_in & use_comp[k]));
    end

endmodule

// File: rtl/mcell_term_router.sv
module mcell_term_router
    import mcell_pkg::*;
#(
    parameter int NPT  = 5,
    parameter int NPAR = 2,
    parameter int NSHR = 4
) (
    input  logic [NPT-1:0]      term,
    input  logic [NPT-1:0][2:0] role,
    input  logic [NPAR-1:0]     borrow_in,
    input  logic [NSHR-1:0]     share_in,
    input  logic                invert,
    output logic                sum_x,
    output logic                pre_o,
    output logic                clr_o,
    output logic                aclk_o,
    output logic                cena_o,
    output logic                aux_o
);

    logic or_local;

    always_comb begin
        or_local = 1'b0;
        pre_o    = 1'b0;
        clr_o    = 1'b0;
        aclk_o   = 1'b0;
        cena_o   = 1'b0;
        aux_o    = 1'b0;
        for (int k = 0; k < NPT; k++) begin
            unique case (pt_role_e'(role[k]))
                ROLE_SUM:    or_local = or_local | term[k];
                ROLE_PRESET: pre_o    = pre_o    | term[k];
                ROLE_CLEAR:  clr_o    = clr_o    | term[k];
                ROLE_ACLK:   aclk_o   = aclk_o   | term[k];
                ROLE_CENA:   cena_o   = cena_o   | term[k];
                ROLE_AUX:    aux_o    = aux_o    | term[k];
                ROLE_IDLE6, ROLE_IDLE7: ;
            endcase
        end
        sum_x = (or_local | (|borrow_in) | (|share_in)) ^ invert;
    end

endmodule

// File: rtl/mcell_clk_src.sv
module mcell_clk_src
    import mcell_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] gclk_pin,
    input  logic       pin_sel,
    input  logic       pin_inv,
    input  logic [1:0] mode,
    input  logic       aclk_term,
    input  logic       cena_term,
    output logic       fire
);

    logic g_raw;
    logic g_prev;
    logic a_prev;
    logic g_rise;
    logic a_rise;

    assign g_raw  = gclk_pin[pin_sel] ^ pin_inv;
    assign g_rise = g_raw & ~g_prev;
    assign a_rise = aclk_term & ~a_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_prev <= 1'b0;
            a_prev <= 1'b0;
        end else begin
            g_prev <= g_raw;
            a_prev <= aclk_term;
        end
    end

    always_comb begin
        unique case (clk_mode_e'(mode))
            CM_GLOBAL: fire = g_rise;
            CM_GATED:  fire = g_rise & cena_term;
            CM_ARRAY:  fire = a_rise;
            CM_OFF:    fire = 1'b0;
        endcase
    end

endmodule

// File: rtl/mcell_ff_eval.sv
module mcell_ff_eval
    import mcell_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       q,
    input  logic       d,
    input  logic       aux,
    output logic       want
);

    always_comb begin
        unique case (ff_kind_e'(kind))
            FF_D:  want = d;
            FF_T:  want = q ^ d;
            FF_JK: want = (d & ~q) | (~aux & q);
            FF_SR: want = (d & ~aux) | (q & (d | ~aux));
        endcase
    end

endmodule

// File: rtl/mcell_cell.sv
module mcell_cell
    import mcell_pkg::*;
#(
    parameter int NIN  = 8,
    parameter int NPT  = 5,
    parameter int NPAR = 2,
    parameter int NSHR = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NIN-1:0]          route_in,
    input  logic [1:0]              gclk_pin,
    input  logic                    gclr_n,
    input  logic [NPAR-1:0]         borrow_in,
    input  logic [NSHR-1:0]         share_in,
    input  logic [NPT-1:0][NIN-1:0] cfg_and_true,
    input  logic [NPT-1:0][NIN-1:0] cfg_and_comp,
    input  logic [NPT-1:0][2:0]     cfg_role,
    input  logic                    cfg_invert,
    input  logic [1:0]              cfg_ff_kind,
    input  logic [1:0]              cfg_clk_mode,
    input  logic                    cfg_pin_sel,
    input  logic                    cfg_pin_inv,
    input  logic                    cfg_bypass,
    output logic                    io_out,
    output logic                    fb_out
);

    logic [NPT-1:0] term;
    logic           sum_x;
    logic           pt_pre;
    logic           pt_clr;
    logic           pt_aclk;
    logic           pt_cena;
    logic           pt_aux;
    logic           fire;
    logic           want;
    logic           force_clr;
    logic           q_one;
    cell_st_e       st_q;
    cell_st_e       st_d;

    mcell_and_array #(.NIN(NIN), .NPT(NPT)) u_and (
        .sig_in   (route_in),
        .use_true (cfg_and_true),
        .use_comp (cfg_and_comp),
        .term     (term)
    );

    mcell_term_router #(.NPT(NPT), .NPAR(NPAR), .NSHR(NSHR)) u_route (
        .term      (term),
        .role      (cfg_role),
        .borrow_in (borrow_in),
        .share_in  (share_in),
        .invert    (cfg_invert),
        .sum_x     (sum_x),
        .pre_o     (pt_pre),
        .clr_o     (pt_clr),
        .aclk_o    (pt_aclk),
        .cena_o    (pt_cena),
        .aux_o     (pt_aux)
    );

    mcell_clk_src u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .gclk_pin  (gclk_pin),
        .pin_sel   (cfg_pin_sel),
        .pin_inv   (cfg_pin_inv),
        .mode      (cfg_clk_mode),
        .aclk_term (pt_aclk),
        .cena_term (pt_cena),
        .fire      (fire)
    );

    assign q_one = (st_q == ST_ONE);

    mcell_ff_eval u_eval (
        .kind (cfg_ff_kind),
        .q    (q_one),
        .d    (sum_x),
        .aux  (pt_aux),
        .want (want)
    );

    assign force_clr = pt_clr | ~gclr_n;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_ZERO;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions: SET, CLEAR, otherwise HOLD
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_ZERO: if (!force_clr && (pt_pre || (fire && want))) st_d = ST_ONE;
            ST_ONE:  if (force_clr || (!pt_pre && fire && !want)) st_d = ST_ZERO;
        endcase
    end

    // Outputs
    always_comb begin
        io_out = cfg_bypass ? sum_x : q_one;
        fb_out = io_out;
    end

endmodule

// File: rtl/mcell_cell_chk.sv
module mcell_cell_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       gclr_n,
    input logic       pt_pre,
    input logic       pt_clr,
    input logic       pt_aux,
    input logic       fire,
    input logic       d_in,
    input logic [1:0] ff_kind,
    input logic       q_one
);

    logic quiet;
    assign quiet = !pt_pre && !pt_clr && gclr_n;

    AST_CLEAR_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_clr || !gclr_n) |=> !q_one); // R10

    AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_pre && !pt_clr && gclr_n) |=> q_one); // R10

    AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && quiet) |=> $stable(q_one)); // R8

    AST_D_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && quiet && ff_kind == 2'd0) |=> (q_one == $past(d_in))); // R4

    AST_T_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && quiet && ff_kind == 2'd1 && d_in) |=> (q_one != $past(q_one))); // R5

    AST_JK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && quiet && ff_kind == 2'd2 && d_in && pt_aux) |=> (q_one != $past(q_one))); // R6

    AST_SR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && quiet && ff_kind == 2'd3 && d_in && pt_aux) |=> (q_one == $past(q_one))); // R7

endmodule

bind mcell_cell mcell_cell_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .gclr_n  (gclr_n),
    .pt_pre  (pt_pre),
    .pt_clr  (pt_clr),
    .pt_aux  (pt_aux),
    .fire    (fire),
    .d_in    (sum_x),
    .ff_kind (cfg_ff_kind),
    .q_one   (q_one)
);

// File: tb/mcell_cell_tb.sv
module mcell_cell_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NIN  = 8;
    localparam int NPT  = 5;
    localparam int NPAR = 2;
    localparam int NSHR = 4;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NIN-1:0]          route_in = '0;
    logic [1:0]              gclk_pin = '0;
    logic                    gclr_n = 1'b1;
    logic [NPAR-1:0]         borrow_in = '0;
    logic [NSHR-1:0]         share_in = '0;
    logic [NPT-1:0][NIN-1:0] cfg_and_true;
    logic [NPT-1:0][NIN-1:0] cfg_and_comp;
    logic [NPT-1:0][2:0]     cfg_role;
    logic                    cfg_invert;
    logic [1:0]              cfg_ff_kind;
    logic [1:0]              cfg_clk_mode;
    logic                    cfg_pin_sel;
    logic                    cfg_pin_inv;
    logic                    cfg_bypass;
    logic                    io_out;
    logic                    fb_out;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcell_cell #(.NIN(NIN), .NPT(NPT), .NPAR(NPAR), .NSHR(NSHR)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .route_in     (route_in),
        .gclk_pin     (gclk_pin),
        .gclr_n       (gclr_n),
        .borrow_in    (borrow_in),
        .share_in     (share_in),
        .cfg_and_true (cfg_and_true),
        .cfg_and_comp (cfg_and_comp),
        .cfg_role     (cfg_role),
        .cfg_invert   (cfg_invert),
        .cfg_ff_kind  (cfg_ff_kind),
        .cfg_clk_mode (cfg_clk_mode),
        .cfg_pin_sel  (cfg_pin_sel),
        .cfg_pin_inv  (cfg_pin_inv),
        .cfg_bypass   (cfg_bypass),
        .io_out       (io_out),
        .fb_out       (fb_out)
    );

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic chk_out(string tag, logic exp);
        chk({tag, " io_out"}, io_out, exp);
        chk({tag, " fb_out"}, fb_out, exp);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // term k follows route_in[k]; roles: sum, aux, enable, array clock, unused
    task automatic cfg_base();
        for (int k = 0; k < NPT; k++) begin
            cfg_and_true[k] = NIN'(1 << k);
            cfg_and_comp[k] = '0;
        end
        cfg_role     = {3'd6, 3'd3, 3'd4, 3'd5, 3'd0};
        cfg_invert   = 1'b0;
        cfg_ff_kind  = 2'd0;
        cfg_clk_mode = 2'd0;
        cfg_pin_sel  = 1'b0;
        cfg_pin_inv  = 1'b0;
        cfg_bypass   = 1'b0;
        route_in     = '0;
        gclk_pin     = '0;
        gclr_n       = 1'b1;
        borrow_in    = '0;
        share_in     = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic pulse(int pin);
        gclk_pin[pin] = 1'b1;
        step(1);
        gclk_pin[pin] = 1'b0;
        step(1);
    endtask

    task automatic t_reset();
        cfg_base();
        do_reset();
        chk_out("R11 after reset", 1'b0);
    endtask

    task automatic t_sop();
        cfg_base();
        cfg_bypass = 1'b1;
        cfg_role   = {3'd6, 3'd7, 3'd6, 3'd0, 3'd0};
        route_in = 8'h00; step(1); chk_out("R2 empty sum", 1'b0);
        route_in = 8'h02; step(1); chk_out("R2 second sum term", 1'b1);
        route_in = 8'h04; step(1); chk_out("R2 unused role ignored", 1'b0);
        route_in = 8'h00; cfg_invert = 1'b1; step(1); chk_out("R2 polarity", 1'b1);
        cfg_invert = 1'b0; borrow_in = 2'b10; step(1); chk_out("R2 borrowed term", 1'b1);
        borrow_in = '0; share_in = 4'b0100; step(1); chk_out("R2 shared term", 1'b1);
        share_in = '0;
        cfg_and_comp[0] = 8'h08;
        route_in = 8'h01; step(1); chk_out("R1 true and complement", 1'b1);
        route_in = 8'h09; step(1); chk_out("R1 complement blocks", 1'b0);
        cfg_and_true[0] = '0; cfg_and_comp[0] = '0;
        route_in = 8'h00; step(1); chk_out("R1 empty mask is 1", 1'b1);
        cfg_bypass = 1'b0; step(1); chk_out("R3 register shown", 1'b0);
        cfg_bypass = 1'b1; step(1); chk_out("R3 bypass shown", 1'b1);
    endtask

    task automatic t_dff();
        cfg_base(); do_reset();
        route_in = 8'h01; pulse(0); chk_out("R4 capture 1", 1'b1);
        route_in = 8'h00; step(3); chk_out("R4 hold between edges", 1'b1);
        pulse(0); chk_out("R4 capture 0", 1'b0);
    endtask

    task automatic t_tff();
        cfg_base(); cfg_ff_kind = 2'd1; do_reset();
        route_in = 8'h01; pulse(0); chk_out("R5 toggle up", 1'b1);
        pulse(0); chk_out("R5 toggle down", 1'b0);
        route_in = 8'h00; pulse(0); chk_out("R5 T=0 holds", 1'b0);
    endtask

    task automatic t_jk();
        cfg_base(); cfg_ff_kind = 2'd2; do_reset();
        route_in = 8'h01; pulse(0); chk_out("R6 J sets", 1'b1);
        route_in = 8'h00; pulse(0); chk_out("R6 00 holds", 1'b1);
        route_in = 8'h03; pulse(0); chk_out("R6 11 toggles down", 1'b0);
        pulse(0); chk_out("R6 11 toggles up", 1'b1);
        route_in = 8'h02; pulse(0); chk_out("R6 K clears", 1'b0);
    endtask

    task automatic t_sr();
        cfg_base(); cfg_ff_kind = 2'd3; do_reset();
        route_in = 8'h01; pulse(0); chk_out("R7 S sets", 1'b1);
        route_in = 8'h03; pulse(0); chk_out("R7 11 holds high", 1'b1);
        route_in = 8'h02; pulse(0); chk_out("R7 R clears", 1'b0);
        route_in = 8'h03; pulse(0); chk_out("R7 11 holds low", 1'b0);
        route_in = 8'h00; pulse(0); chk_out("R7 00 holds", 1'b0);
    endtask

    task automatic t_clk_modes();
        cfg_base(); cfg_clk_mode = 2'd1; do_reset();
        route_in = 8'h01; pulse(0); chk_out("R8 enable low blocks", 1'b0);
        route_in = 8'h05; pulse(0); chk_out("R8 enable high clocks", 1'b1);
        cfg_clk_mode = 2'd2; route_in = 8'h00; step(2);
        pulse(0); chk_out("R8 array mode ignores global", 1'b1);
        route_in = 8'h08; step(1); chk_out("R8 array clock rise", 1'b0);
        route_in = 8'h09; step(2); chk_out("R8 array level no clock", 1'b0);
        route_in = 8'h01; step(1);
        route_in = 8'h09; step(1); chk_out("R8 array second rise", 1'b1);
        cfg_clk_mode = 2'd3; route_in = 8'h00; step(1);
        pulse(0); route_in = 8'h08; step(1); chk_out("R8 mode 3 never clocks", 1'b1);
    endtask

    task automatic t_gclk_sel();
        cfg_base(); cfg_pin_sel = 1'b1; do_reset();
        route_in = 8'h01; pulse(0); chk_out("R9 unselected pin ignored", 1'b0);
        pulse(1); chk_out("R9 selected pin clocks", 1'b1);
        route_in = 8'h00; gclk_pin = 2'b11; step(2); chk_out("R9 rise captures 0", 1'b0);
        cfg_pin_inv = 1'b1; route_in = 8'h01; step(2); chk_out("R9 inverted high idle", 1'b0);
        gclk_pin = 2'b00; step(1); chk_out("R9 inverted falling pin clocks", 1'b1);
    endtask

    task automatic t_async();
        cfg_base(); cfg_role = {3'd1, 3'd2, 3'd4, 3'd5, 3'd0}; do_reset();
        route_in = 8'h10; step(1); chk_out("R10 preset without clock", 1'b1);
        route_in = 8'h00; step(2); chk_out("R10 preset released holds", 1'b1);
        route_in = 8'h08; step(1); chk_out("R10 clear without clock", 1'b0);
        route_in = 8'h18; step(1); chk_out("R10 clear beats preset", 1'b0);
        route_in = 8'h10; gclr_n = 1'b0; step(1); chk_out("R10 global clear beats preset", 1'b0);
        gclr_n = 1'b1; step(1); chk_out("R10 preset after global clear", 1'b1);
        route_in = 8'h11; gclk_pin[0] = 1'b1; route_in = 8'h18; step(1);
        gclk_pin[0] = 1'b0; chk_out("R10 clear beats clock event", 1'b0);
        route_in = 8'h10; step(1); route_in = 8'h00; step(1);
        do_reset(); chk_out("R11 reset clears set register", 1'b0);
    endtask

    // Reference model over random configurations
    function automatic logic [NPT-1:0] m_terms(logic [NIN-1:0] v);
        logic [NPT-1:0] r;
        for (int k = 0; k < NPT; k++) begin
            r[k] = 1'b1;
            for (int i = 0; i < NIN; i++) begin
                if (cfg_and_true[k][i] && !v[i]) r[k] = 1'b0;
                if (cfg_and_comp[k][i] && v[i])  r[k] = 1'b0;
            end
        end
        return r;
    endfunction

    task automatic t_random();
        logic q_m, pg_m, pa_m;
        cfg_base(); do_reset();
        q_m = 1'b0; pg_m = 1'b0; pa_m = 1'b0;
        for (int c = 0; c < 300; c++) begin
            for (int k = 0; k < NPT; k++) begin
                cfg_and_true[k] = NIN'($urandom & $urandom & $urandom);
                cfg_and_comp[k] = NIN'($urandom & $urandom & $urandom);
                cfg_role[k]     = 3'($urandom_range(0, 7));
            end
            cfg_invert   = 1'($urandom);
            cfg_ff_kind  = 2'($urandom);
            cfg_clk_mode = 2'($urandom);
            cfg_pin_sel  = 1'($urandom);
            cfg_pin_inv  = 1'($urandom);
            cfg_bypass   = ($urandom_range(0, 3) == 0);
            for (int s = 0; s < 16; s++) begin
                logic [NPT-1:0] t;
                logic sum_v, pre_v, clr_v, ac_v, en_v, aux_v, rg, fire_v, want_v, nq;
                route_in  = NIN'($urandom);
                gclk_pin  = 2'($urandom);
                borrow_in = ($urandom_range(0, 5) == 0) ? NPAR'($urandom) : '0;
                share_in  = ($urandom_range(0, 5) == 0) ? NSHR'($urandom) : '0;
                gclr_n    = ($urandom_range(0, 9) != 0);
                t = m_terms(route_in);
                sum_v = 0; pre_v = 0; clr_v = 0; ac_v = 0; en_v = 0; aux_v = 0;
                for (int k = 0; k < NPT; k++) begin
                    if (cfg_role[k] == 3'd0) sum_v |= t[k];
                    if (cfg_role[k] == 3'd1) pre_v |= t[k];
                    if (cfg_role[k] == 3'd2) clr_v |= t[k];
                    if (cfg_role[k] == 3'd3) ac_v  |= t[k];
                    if (cfg_role[k] == 3'd4) en_v  |= t[k];
                    if (cfg_role[k] == 3'd5) aux_v |= t[k];
                end
                sum_v = (sum_v | (|borrow_in) | (|share_in)) ^ cfg_invert;
                rg = gclk_pin[cfg_pin_sel] ^ cfg_pin_inv;
                case (cfg_clk_mode)
                    2'd0:    fire_v = rg && !pg_m;
                    2'd1:    fire_v = rg && !pg_m && en_v;
                    2'd2:    fire_v = ac_v && !pa_m;
                    default: fire_v = 1'b0;
                endcase
                case (cfg_ff_kind)
                    2'd0: want_v = sum_v;
                    2'd1: want_v = sum_v ? !q_m : q_m;
                    2'd2: want_v = (sum_v && aux_v) ? !q_m : (sum_v ? 1'b1 : (aux_v ? 1'b0 : q_m));
                    default: want_v = (sum_v && !aux_v) ? 1'b1 : ((!sum_v && aux_v) ? 1'b0 : q_m);
                endcase
                if (clr_v || !gclr_n) nq = 1'b0;
                else if (pre_v)       nq = 1'b1;
                else if (fire_v)      nq = want_v;
                else                  nq = q_m;
                @(posedge clk);
                #1;
                q_m = nq; pg_m = rg; pa_m = ac_v;
                // all of R1-style term building through R10 priority are exercised here
                chk("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 random model", io_out, cfg_bypass ? sum_v : q_m);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        cfg_base();
        step(2);
        t_reset();
        t_sop();
        t_dff();
        t_tff();
        t_jk();
        t_sr();
        t_clk_modes();
        t_gclk_sel();
        t_async();
        t_random();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule